// File: doc/BRIEF.md
# Serial Voltage/Current Read Master

This block runs one read transaction on a regulator management link that uses a four-wire serial interface in clock mode 0 (clock idles low, data sampled on the rising edge). The host asks for one reading, a voltage or a current, on one of sixteen rails. The block builds the 32-bit command word and protects it with a 3-bit CRC. It shifts the word out most significant bit first and captures the 32-bit reply on the same clock edges. It then checks the reply and returns the 16-bit reading together with its status flags.

The serial clock comes from the core clock through a 10-bit divider value that the host supplies with each request. One serial clock period lasts 8 × (divider + 1) core cycles, so the divider for a target rate is core_MHz / (8 × bus_MHz) − 1 (4 for a 400 MHz core and a 10 MHz bus). The whole 32-bit exchange runs as two 16-bit halves back to back, with chip select held low from start to finish.

Top module: `avs_read_master`

## Requirements
- R1: After reset, spi_csn is 1, spi_sclk is 0, and busy, done, err_crc, err_ack, err_fsm and rd_value are all 0.
- R2: The command word, from bit 31 down to bit 0, is: 2'b01, 2'b11, 1'b0, a 4-bit type code (4'h0 when req_current is 0, 4'h2 when it is 1), the 4-bit rail, sixteen ones, and the 3-bit CRC.
- R3: The CRC is the remainder of (bits 31:3 × x^3) divided by x^3 + x + 1. It goes in bits 2:0 of the command word, and the reply CRC is computed the same way.
- R4: Mode 0 timing: spi_sclk is low whenever spi_csn is high, spi_mosi never changes at a rising spi_sclk edge, and spi_miso is sampled on rising edges.
- R5: spi_sclk stays high for 4 × (div_value + 1) core cycles in each bit. Chip select falls one full serial period before the first rising edge and rises one full period after the last falling edge, so it stays low for 268 × (div_value + 1) core cycles.
- R6: A reply whose CRC matches and whose acknowledge field (bits 31:30) is 2'b00 sets rd_value to reply bits 23:8 and clears both error flags.
- R7: A reply CRC mismatch sets err_crc, clears err_ack and forces rd_value to 0, whatever the acknowledge field holds.
- R8: A reply with a matching CRC and an acknowledge field other than 2'b00 sets err_ack, clears err_crc and forces rd_value to 0.
- R9: busy is 1 from the cycle after the request until the result. done is a single-cycle pulse, raised in the same cycle that busy falls and the result outputs take their new values.
- R10: A request made while busy is ignored: the frame being sent and the chip-select window are unchanged, and no second transaction follows.
- R11: Each transaction has exactly 32 rising spi_sclk edges inside one chip-select window. err_fsm stays 0 in legal operation and is set only if the controller state leaves its legal set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a read (taken only when idle) |
| req_current | input | 1 | 0 selects voltage, 1 selects current |
| req_rail | input | 4 | Rail select |
| div_value | input | 10 | Serial clock divider, captured with the request |
| spi_miso | input | 1 | Serial data from the regulator |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_csn | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the regulator |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse: result outputs valid |
| rd_value | output | 16 | Reading (0 when the reply is rejected) |
| err_crc | output | 1 | Reply CRC mismatch |
| err_ack | output | 1 | Reply acknowledge not 2'b00 |
| err_fsm | output | 1 | Controller state was illegal |

## Verification
The bench sweeps every rail with both command types at divider 0. Because the rail and type feed the CRC, checking the captured frame across the sweep separates each field placement and every CRC remainder class. Reply patterns rotate through five kinds: good, corrupted CRC, bad acknowledge, bad acknowledge combined with bad CRC, and acknowledge 11. These tell the CRC-before-acknowledge priority apart from either check alone. A few runs at divider 2 separate the divider scaling from a fixed timing, and requests fired mid-transfer show whether a busy request can disturb the frame or the chip-select window.

// File: rtl/avs_read_pkg.sv
// Package: shared constants and the controller state type for the
// serial voltage/current read master. Assumes a 32-bit frame.
package avs_read_pkg;
    localparam int FRAME_W  = 32;
    localparam int CRC_W    = 3;
    localparam logic [3:0] TYPE_VOLTAGE = 4'h0;
    localparam logic [3:0] TYPE_CURRENT = 4'h2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_TRAIL = 3'd3
    } ctl_state_t;
endpackage

// File: rtl/avs_crc3.sv
// Module: 3-bit CRC, generator x^3 + x + 1, over DATA_W message bits
// (message followed by three zero bits). Purely combinational.
module avs_crc3 #(
    parameter int DATA_W = 29
) (
    input  logic [DATA_W-1:0] data,
    output logic [2:0]        crc
);
    // Serial LFSR unrolled over the message, most significant bit first.
    always_comb begin
        logic [2:0] r;
        logic       fb;
        r = 3'b000;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = data[i] ^ r[2];
            r  = {r[1], r[0] ^ fb, fb};
        end
        crc = r;
    end
endmodule

// File: rtl/avs_cmd_frame.sv
// Module: assembles the 32-bit read command word from the type code and
// rail, and appends the CRC. Assumes 4-bit type and rail fields.
module avs_cmd_frame #(
    parameter int TYPE_W = 4,
    parameter int RAIL_W = 4
) (
    input  logic [TYPE_W-1:0]                 type_code,
    input  logic [RAIL_W-1:0]                 rail,
    output logic [avs_read_pkg::FRAME_W-1:0]  frame
);
    localparam int BODY_W = avs_read_pkg::FRAME_W - avs_read_pkg::CRC_W;
    localparam int FILL_W = BODY_W - 5 - TYPE_W - RAIL_W;

    logic [BODY_W-1:0] body;
    logic [2:0]        crc;

    // Fixed prefix (start 01, read 11, group 0), fields, then the ones fill.
    always_comb body = {2'b01, 2'b11, 1'b0, type_code, rail, {FILL_W{1'b1}}};

    avs_crc3 #(.DATA_W(BODY_W)) u_crc (.data(body), .crc(crc));

    // Final word: body followed by its check bits.
    always_comb frame = {body, crc};
endmodule

// File: rtl/avs_sclk_tick.sv
// Module: produces a one-cycle tick every 4*(div+1) core cycles while
// enabled; each tick is one serial clock half period. Restarts when en drops.
module avs_sclk_tick #(
    parameter int DIV_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Terminal count is 4*div + 3.
    always_comb limit = {div, 2'b11};
    always_comb tick  = en && (cnt_q == limit);

    // Half-period counter, held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!en || tick) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    // R5: ticks are never adjacent (minimum spacing of four cycles).
    a_r5_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/avs_read_master.sv
// Module: one voltage or current read over a mode-0 serial link. Accepts a
// request while idle, shifts the command out and the reply in across one
// chip-select window, then checks the reply CRC (first) and acknowledge.
// Assumes div_value is held stable only at the request cycle (it is captured).
module avs_read_master
    import avs_read_pkg::*;
#(
    parameter int DIV_W  = 10,
    parameter int RAIL_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_current,
    input  logic [RAIL_W-1:0] req_rail,
    input  logic [DIV_W-1:0]  div_value,
    input  logic              spi_miso,
    output logic              spi_sclk,
    output logic              spi_csn,
    output logic              spi_mosi,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_value,
    output logic              err_crc,
    output logic              err_ack,
    output logic              err_fsm
);
    localparam int BIT_W  = $clog2(FRAME_W);
    localparam int BODY_W = FRAME_W - CRC_W;
    localparam int VAL_LO = 8;

    ctl_state_t          state_q;
    logic                sclk_q, csn_q, ph_q, done_q;
    logic [FRAME_W-1:0]  tx_q, rx_q, cmd_word;
    logic [BIT_W-1:0]    bit_q;
    logic [DIV_W-1:0]    div_q;
    logic [DATA_W-1:0]   val_q;
    logic                crc_err_q, ack_err_q, fsm_err_q;
    logic                tick, crc_ok, ack_ok;
    logic [2:0]          rx_crc;
    logic [3:0]          type_code;

    // Type code chosen by the request kind.
    always_comb type_code = req_current ? TYPE_CURRENT : TYPE_VOLTAGE;

    avs_cmd_frame #(.TYPE_W(4), .RAIL_W(RAIL_W)) u_frame (
        .type_code(type_code), .rail(req_rail), .frame(cmd_word));

    avs_sclk_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(state_q != ST_IDLE),
        .div(div_q), .tick(tick));

    avs_crc3 #(.DATA_W(BODY_W)) u_rx_crc (
        .data(rx_q[FRAME_W-1:CRC_W]), .crc(rx_crc));

    // Reply checks: CRC match and a zero acknowledge field.
    always_comb crc_ok = (rx_crc == rx_q[CRC_W-1:0]);
    always_comb ack_ok = (rx_q[FRAME_W-1 -: 2] == 2'b00);

    // Transaction sequencer: lead period, 32 bits, trail period, result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sclk_q    <= 1'b0;
            csn_q     <= 1'b1;
            ph_q      <= 1'b0;
            done_q    <= 1'b0;
            tx_q      <= '0;
            rx_q      <= '0;
            bit_q     <= '0;
            div_q     <= '0;
            val_q     <= '0;
            crc_err_q <= 1'b0;
            ack_err_q <= 1'b0;
            fsm_err_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        tx_q      <= cmd_word;
                        div_q     <= div_value;
                        csn_q     <= 1'b0;
                        ph_q      <= 1'b0;
                        bit_q     <= '0;
                        fsm_err_q <= 1'b0;
                        state_q   <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        if (!ph_q) begin
                            ph_q <= 1'b1;
                        end else begin
                            sclk_q  <= 1'b1;
                            rx_q    <= {rx_q[FRAME_W-2:0], spi_miso};
                            state_q <= ST_SHIFT;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                            if (bit_q == BIT_W'(FRAME_W - 1)) begin
                                ph_q    <= 1'b0;
                                state_q <= ST_TRAIL;
                            end else begin
                                tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
                                bit_q <= bit_q + 1'b1;
                            end
                        end else begin
                            sclk_q <= 1'b1;
                            rx_q   <= {rx_q[FRAME_W-2:0], spi_miso};
                        end
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        if (!ph_q) begin
                            ph_q <= 1'b1;
                        end else begin
                            csn_q     <= 1'b1;
                            done_q    <= 1'b1;
                            crc_err_q <= !crc_ok;
                            ack_err_q <= crc_ok && !ack_ok;
                            val_q     <= (crc_ok && ack_ok) ?
                                         rx_q[VAL_LO +: DATA_W] : '0;
                            state_q   <= ST_IDLE;
                        end
                    end
                end
                default: begin
                    sclk_q    <= 1'b0;
                    csn_q     <= 1'b1;
                    fsm_err_q <= 1'b1;
                    state_q   <= ST_IDLE;
                end
            endcase
        end
    end

    // Output drive from registers.
    always_comb begin
        spi_sclk = sclk_q;
        spi_csn  = csn_q;
        spi_mosi = tx_q[FRAME_W-1];
        busy     = (state_q != ST_IDLE);
        done     = done_q;
        rd_value = val_q;
        err_crc  = crc_err_q;
        err_ack  = ack_err_q;
        err_fsm  = fsm_err_q;
    end

    // R4: the serial clock is low whenever chip select is released.
    a_r4_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_sclk);
    // R4: data out does not move at a rising serial clock edge.
    a_r4_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));
    // R9: done lasts one cycle.
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: the result is flagged only once the block is idle again.
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && spi_csn));
    // R7: CRC and acknowledge errors never appear together.
    a_r7_flag_priority: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_crc && err_ack));
    // R10: the outgoing word holds still until the first rising edge.
    a_r10_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LEAD) && !tick |=> $stable(tx_q));
endmodule

// File: tb/avs_read_master_test.sv
// Bench: sweeps rails, types and reply kinds against a behavioural slave.
module avs_read_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_current = 1'b0;
    logic [3:0]  req_rail = '0;
    logic [9:0]  div_value = '0;
    logic        spi_miso = 1'b1;
    logic        spi_sclk, spi_csn, spi_mosi, busy, done;
    logic [15:0] rd_value;
    logic        err_crc, err_ack, err_fsm;

    int checks = 0, failures = 0, cycles = 0;
    int low_cnt = 0, high_cnt = 0, rise_cnt = 0, csn_falls = 0;
    logic [31:0] resp_sh, cap;
    bit          finished = 0;

    always #2 clk = ~clk;

    avs_read_master uut (.*);

    // Slave: presents the reply MSB first, changes on falling clock.
    always @(negedge spi_csn) begin
        csn_falls++;
        spi_miso = resp_sh[31];
    end
    always @(posedge spi_sclk) begin
        cap = {cap[30:0], spi_mosi};
        rise_cnt++;
    end
    always @(negedge spi_sclk) begin
        resp_sh  = {resp_sh[30:0], 1'b1};
        spi_miso = resp_sh[31];
    end

    // Monitor and watchdog, sampled away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (!spi_csn)  low_cnt++;
        if (spi_sclk)  high_cnt++;
        if (cycles > 150000 && !finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got %0d expected <150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Long division by 1011 over bits 31:3 with bits 2:0 zero.
    function automatic logic [2:0] ref_crc(input logic [31:0] w);
        logic [31:0] v;
        v = {w[31:3], 3'b000};
        for (int i = 31; i >= 3; i--)
            if (v[i]) v = v ^ (32'hB << (i - 3));
        return v[2:0];
    endfunction

    // One transaction; mode: 0 good, 1 bad CRC, 2 ack 01, 3 ack 10 + bad CRC, 4 ack 11.
    task automatic run(input logic [3:0] rail, input logic kind,
                       input logic [9:0] dv, input int mode, input bit poke);
        logic [31:0] exp_cmd, resp;
        logic [15:0] reading;
        logic [1:0]  ack;
        bit          bad_crc, good;
        int          waited;
        reading = {rail, 3'b101, kind, ~rail, rail ^ 4'h9};
        ack     = (mode == 2) ? 2'b01 : (mode == 3) ? 2'b10 :
                  (mode == 4) ? 2'b11 : 2'b00;
        bad_crc = (mode == 1) || (mode == 3);
        resp    = {ack, 1'b0, 5'b00000, reading, 5'b11111, 3'b000};
        resp[2:0] = ref_crc(resp) ^ (bad_crc ? 3'b001 : 3'b000);
        good    = !bad_crc && (ack == 2'b00);
        exp_cmd = {2'b01, 2'b11, 1'b0, (kind ? 4'h2 : 4'h0), rail, 16'hFFFF, 3'b000};
        exp_cmd[2:0] = ref_crc(exp_cmd);

        @(negedge clk);
        resp_sh = resp; cap = '0;
        low_cnt = 0; high_cnt = 0; rise_cnt = 0; csn_falls = 0;
        req_rail = rail; req_current = kind; div_value = dv; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy after request", {31'b0, busy}, 32'd1);
        if (poke) begin
            repeat (90) @(negedge clk);
            req_rail = ~rail; req_current = ~kind; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        waited = 0;
        while (!done && waited < 6000) begin
            @(negedge clk);
            waited++;
        end
        chk("R9 done seen", {31'b0, done}, 32'd1);
        chk("R9 busy low at done", {31'b0, busy}, 32'd0);
        chk("R2 R3 command word", cap, exp_cmd);
        chk("R6 R7 R8 reading", {16'b0, rd_value}, good ? {16'b0, reading} : 32'd0);
        chk("R7 crc flag", {31'b0, err_crc}, {31'b0, bad_crc});
        chk("R8 ack flag", {31'b0, err_ack}, {31'b0, !bad_crc && ack != 2'b00});
        chk("R11 fsm flag", {31'b0, err_fsm}, 32'd0);
        chk("R11 rising edges", rise_cnt, 32'd32);
        chk("R5 csn window", low_cnt, 268 * (dv + 1));
        chk("R5 sclk high time", high_cnt, 128 * (dv + 1));
        @(negedge clk);
        chk("R9 done one cycle", {31'b0, done}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R10 single window", csn_falls, 32'd1);
        chk("R10 idle after", {30'b0, busy, spi_csn}, 32'd1);
    endtask

    initial begin
        resp_sh = '1; cap = '0;
        repeat (4) @(negedge clk);
        chk("R1 reset csn/sclk", {30'b0, spi_csn, spi_sclk}, 32'd2);
        chk("R1 reset busy/done", {30'b0, busy, done}, 32'd0);
        chk("R1 reset flags", {29'b0, err_crc, err_ack, err_fsm}, 32'd0);
        chk("R1 reset value", {16'b0, rd_value}, 32'd0);
        rst_n = 1'b1;
        for (int r = 0; r < 16; r++)
            for (int k = 0; k < 2; k++)
                run(4'(r), 1'(k), 10'd0, (r + k) % 5, (r % 4) == 1);
        for (int m = 0; m < 5; m++)
            run(4'(m * 3), 1'(m % 2), 10'd2, m, m == 2);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule